// File: doc/BRIEF.md
# Quad DAC Serial Input Register

This block is the digital front end of a four-channel, 12-bit digital-to-analog converter. A host shifts 16-bit command words into it over a three-wire serial link: a serial clock, a data line, and an active-low frame enable. Each word names one of four channels and carries a 12-bit code for it. The word waits in a holding stage. A separate active-low load strobe then writes it into the addressed channel register. The four channel codes drive the converter cores, which are outside this block.

The serial clock idles high. The host changes data while the clock is low, and the block takes a bit on each rising clock edge. The serial pins, the frame enable and the load strobe are brought into the block clock domain through synchronizer flops and are treated as edges there. An active-low asynchronous clear sets every channel at once to either zero scale or mid scale. A select input chooses which.

Top module: `quad_dac_input_reg`

## Requirements
- R1: After `rst_n` is released, every channel code reads 0x000.
- R2: A word is 16 bits, most significant bit first, and a bit is taken on each rising edge of `sclk` while `cs_n` is low. Word bits 15:14 are the channel address, bits 13:12 are ignored, and bits 11:0 are the code.
- R3: Address 0 writes channel 0, address 1 writes channel 1, address 2 writes channel 2 and address 3 writes channel 3. Channel i appears on `ch_code[12*i+11:12*i]`.
- R4: Shifting a word does not change any channel code. Only a falling edge on `ld_n` moves the held code into the addressed channel.
- R5: A falling edge on `ld_n` when no complete word has arrived since the previous load leaves every channel unchanged.
- R6: A frame that ends with fewer than 16 bits is discarded. A new frame also drops any complete word that has not yet been loaded. A load after either case changes nothing.
- R7: Bits after the sixteenth in one frame are ignored. The first 16 bits form the word.
- R8: While `clr_n` is low with `clr_sel` low, every channel code is 0x000, and this takes effect without waiting for a clock edge.
- R9: While `clr_n` is low with `clr_sel` high, every channel code is 0x800.
- R10: Clear wins over load. A load strobe given while `clr_n` is low changes nothing, and the channels keep the clear value after `clr_n` returns high.
- R11: Rising edges of `sclk` while `cs_n` is high do not alter the held word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles high, bits taken on rising edge |
| sdi | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low frame enable |
| ld_n | input | 1 | Active-low load strobe, acts on its falling edge |
| clr_n | input | 1 | Active-low asynchronous clear of all channels |
| clr_sel | input | 1 | Clear value select: 0 gives zero scale, 1 gives mid scale |
| ch_code | output | 48 | Four 12-bit channel codes, channel 0 in the low bits |

## Verification
The clear assertions assume that `clr_sel` stays steady while `clr_n` is low. The hold assertion assumes that a clear pulse spans at least one clock edge. The bench therefore sets `clr_sel` before it lowers `clr_n`, and it holds every clear for several cycles. The serial checks also assume that each level on `sclk`, `sdi`, `cs_n` and `ld_n` lasts well beyond the synchronizer depth. The stimulus holds every level for four clock cycles and changes inputs only on falling clock edges.

// File: rtl/quad_dac_input_reg.sv
module quad_dac_input_reg #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 2,
  parameter int PAD_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sclk,
  input  logic                            sdi,
  input  logic                            cs_n,
  input  logic                            ld_n,
  input  logic                            clr_n,
  input  logic                            clr_sel,
  output logic [(1<<ADDR_W)*DATA_W-1:0]   ch_code
);
  localparam int NCH    = 1 << ADDR_W;
  localparam int WORD_W = ADDR_W + PAD_W + DATA_W;
  localparam int KEEP_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] PAD_LO  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] PAD_HI  = CNT_W'(ADDR_W + PAD_W);
  localparam logic [DATA_W-1:0] ZERO   = '0;
  localparam logic [DATA_W-1:0] MID    = {1'b1, {(DATA_W-1){1'b0}}};

  logic [SYNC_N-1:0] sclk_s, sdi_s, cs_s, ld_s;
  logic sclk_d, cs_d, ld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '1;
      sdi_s  <= '0;
      cs_s   <= '1;
      ld_s   <= '1;
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
      ld_d   <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[SYNC_N-2:0], sclk};
      sdi_s  <= {sdi_s[SYNC_N-2:0], sdi};
      cs_s   <= {cs_s[SYNC_N-2:0], cs_n};
      ld_s   <= {ld_s[SYNC_N-2:0], ld_n};
      sclk_d <= sclk_s[SYNC_N-1];
      cs_d   <= cs_s[SYNC_N-1];
      ld_d   <= ld_s[SYNC_N-1];
    end
  end

  wire sclk_q    = sclk_s[SYNC_N-1];
  wire cs_q      = cs_s[SYNC_N-1];
  wire ld_q      = ld_s[SYNC_N-1];
  wire sclk_rise = sclk_q & ~sclk_d;
  wire cs_fall   = ~cs_q & cs_d;
  wire cs_rise   = cs_q & ~cs_d;
  wire ld_fall   = ~ld_q & ld_d;

  logic [KEEP_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              rdy;

  wire in_pad = (cnt >= PAD_LO) && (cnt < PAD_HI);
  wire take   = sclk_rise && !cs_q && !cs_fall && (cnt != FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      rdy <= 1'b0;
    end else begin
      if (cs_fall) begin
        cnt <= '0;
        rdy <= 1'b0;
      end else if (cs_rise) begin
        cnt <= '0;
      end else if (take) begin
        cnt <= cnt + 1'b1;
        if (!in_pad) sh <= {sh[KEEP_W-2:0], sdi_s[SYNC_N-1]};
        if (cnt == FULL - 1'b1) rdy <= 1'b1;
      end
      if (ld_fall) rdy <= 1'b0;
    end
  end

  wire [ADDR_W-1:0] addr = sh[KEEP_W-1 -: ADDR_W];
  wire [DATA_W-1:0] data = sh[DATA_W-1:0];
  wire arst_n = rst_n & clr_n;
  wire [DATA_W-1:0] clr_val = (rst_n && clr_sel) ? MID : ZERO;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
        q <= clr_val;
      else if (ld_fall && rdy && addr == ADDR_W'(gi))
        q <= data;
    end
    assign ch_code[gi*DATA_W +: DATA_W] = q;
  end

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  a_r5_load_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall |=> !rdy);

  a_r6_partial_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt != FULL) |-> !rdy);

  a_r11_idle_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && cs_d && sclk_rise) |=> $stable(sh));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !(ld_fall && rdy)) |=> (!clr_n || $stable(ch_code)));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && $past(!clr_n) && !clr_sel && $past(!clr_sel)) |-> ch_code == '0);

  a_r9_clear_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && $past(!clr_n) && clr_sel && $past(clr_sel)) |-> ch_code == {NCH{MID}});
endmodule

// File: tb/quad_dac_input_reg_tb.sv
module quad_dac_input_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sdi = 1'b0, cs_n = 1'b1, ld_n = 1'b1;
  logic clr_n = 1'b1, clr_sel = 1'b0;
  logic [47:0] ch_code;
  logic [11:0] m [4];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quad_dac_input_reg dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .ld_n(ld_n), .clr_n(clr_n), .clr_sel(clr_sel), .ch_code(ch_code));

  localparam logic [15:0] VEC [8] = '{
    16'h0123, 16'h4ABC, 16'h8FFF, 16'hC001,
    16'h3555, 16'h7800, 16'hB7FF, 16'hF000};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int n);
    cs_n = 1'b0; tick(4);
    for (int b = n - 1; b >= 0; b--) begin
      sclk = 1'b0; sdi = w[b]; tick(4);
      sclk = 1'b1; tick(4);
    end
    tick(2); cs_n = 1'b1; tick(4);
  endtask

  task automatic load();
    ld_n = 1'b0; tick(4);
    ld_n = 1'b1; tick(6);
  endtask

  task automatic check(input string req, input logic [47:0] exp);
    n_chk++;
    if (ch_code !== exp) begin
      n_fail++;
      $display("FAIL %s: ch_code=%h expected %h", req, ch_code, exp);
    end
  endtask

  function automatic logic [47:0] model();
    return {m[3], m[2], m[1], m[0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    foreach (m[i]) m[i] = 12'h000;
    tick(5); rst_n = 1'b1; tick(5);
    check("R1 reset", 48'h0);

    foreach (VEC[k]) begin
      send({16'h0, VEC[k]}, 16);
      check("R4 no change before load", model());
      load();
      m[VEC[k][15:14]] = VEC[k][11:0];
      check("R2 R3 load to addressed channel", model());
    end

    load();
    check("R5 repeated load without word", model());

    send(32'h0000_4123, 10);
    load();
    check("R6 partial frame discarded", model());

    send(32'h0000_8AAA, 16);
    send(32'h0000_C000, 5);
    load();
    check("R6 new frame drops unloaded word", model());

    send({16'h0, 16'h1ABC, 4'hF}, 20);
    load();
    m[0] = 12'hABC;
    check("R7 extra bits ignored", model());

    send(32'h0000_95A5, 16);
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b0; sdi = 1'b1; tick(4);
      sclk = 1'b1; tick(4);
    end
    load();
    m[2] = 12'h5A5;
    check("R11 sclk ignored with cs_n high", model());

    clr_sel = 1'b0; tick(1);
    @(posedge clk); #1 clr_n = 1'b0; #0.5;
    check("R8 async zero clear", 48'h0);
    tick(4); clr_n = 1'b1; tick(4);
    check("R8 zero after clear release", 48'h0);

    send(32'h0000_4321, 16);
    load();
    clr_sel = 1'b1; tick(2);
    clr_n = 1'b0; tick(3);
    check("R9 mid clear", {4{12'h800}});

    send(32'h0000_C777, 16);
    load();
    check("R10 load during clear ignored", {4{12'h800}});
    clr_n = 1'b1; tick(4);
    check("R10 clear value kept after release", {4{12'h800}});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule